// File: doc/BRIEF.md
# Transport Stream Sync Acquisition Unit

This unit locks onto a packetized byte stream by finding a repeating marker byte that opens every packet. The marker value, the packet length in bytes and a track-step count are configuration inputs. The stream arrives either as whole bytes that are already byte-aligned, or as single bits. In bit mode the unit finds the byte boundary by itself, at whichever of the eight bit offsets the marker turns up.

A three-state flywheel runs the search. In the search state it waits for a first candidate marker. In the acquiring state it confirms that the marker repeats exactly one packet length later. In the locked state it keeps tracking the marker and tolerates isolated misses. While locked, the unit passes every aligned byte downstream and pulses a packet-start strobe on each marker position.

Top module: `ts_sync_acq`

## Requirements
- R1: While `rst` is high, and on the cycle after `rst` is sampled high, `sync_ok`, `pkt_start` and `out_valid` are low.
- R2: In byte mode (`cfg_serial`=0), every byte sampled with `par_valid` is a candidate. Lock is declared when the byte equal to `cfg_sync_byte` has been seen TS times in a row, each time exactly `cfg_period` bytes after the previous one. TS is decoded from `cfg_steps` as 0→3, 1→4, 2→5 and 3→5, and `cfg_period` ranges from 2 up to 2^PERIOD_W−1 (204 included).
- R3: In bit mode (`cfg_serial`=1), bits are sampled on `ser_bit` with `ser_valid`, most significant bit first. The marker is found at any bit offset, and after lock `out_byte` carries bytes aligned to it.
- R4: In the acquiring state, a wrong byte at the expected marker position returns the unit to search. A later lock then needs a full TS new detections.
- R5: In the locked state, TS consecutive misses at expected marker positions drop `sync_ok`. The drop is visible with the output of the TS-th missed position.
- R6: In the locked state, one correct marker detection clears the count of consecutive misses.
- R7: `pkt_start` is a one-cycle pulse. It is issued with the output of every expected marker position while lock is held, including the position that declares lock, and never on any other byte.
- R8: `out_valid` and `out_byte` present each aligned byte processed while lock is held. A byte sampled with `par_valid` at clock edge k appears after edge k+1. `out_valid` is never high without `sync_ok`.
- R9: A change of `cfg_serial`, `cfg_sync_byte`, `cfg_period` or `cfg_steps` sampled at a clock edge returns the unit to search, with `sync_ok` low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_serial | input | 1 | 1 selects bit input, 0 selects byte input |
| cfg_sync_byte | input | 8 | Marker byte value |
| cfg_period | input | PERIOD_W | Packet length in bytes |
| cfg_steps | input | 2 | Track-step code (0→3, 1→4, 2/3→5) |
| par_valid | input | 1 | Byte input qualifier |
| par_byte | input | 8 | Byte input |
| ser_valid | input | 1 | Bit input qualifier |
| ser_bit | input | 1 | Bit input, MSB of each byte first |
| sync_ok | output | 1 | Lock held |
| pkt_start | output | 1 | Marker position strobe while locked |
| out_valid | output | 1 | Aligned byte qualifier while locked |
| out_byte | output | 8 | Aligned byte |

## Verification
A table of configurations feeds clean packet trains. These cover byte and bit mode, every track-step code, several marker values, packet lengths from 2 to 204, and leading junk of zero to seven bits or several bytes. Each marker is followed by a check of the lock flag, which shows whether lock comes at exactly the TS-th detection and not one earlier or later. It also shows whether bit mode finds the boundary at every offset. Directed trains then corrupt a marker during acquisition, which separates a proper restart from a simple count pause. A miss-miss-hit-miss-miss-miss pattern while locked separates a miss counter that the hit clears from one that keeps counting. Last, the configuration is changed and reset is applied while locked.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;

    localparam logic [7:0] DEF_SYNC_BYTE = 8'h47;
    localparam int         DEF_PERIOD    = 204;

    typedef enum logic [1:0] {
        FW_SEARCH = 2'd0,
        FW_ACQ    = 2'd1,
        FW_TRACK  = 2'd2
    } fw_state_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] data;
    } abyte_t;

    function automatic logic [2:0] steps_decode(input logic [1:0] code);
        case (code)
            2'd0:    steps_decode = 3'd3;
            2'd1:    steps_decode = 3'd4;
            default: steps_decode = 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/ts_cfg_watch.sv
module ts_cfg_watch #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_serial,
    input  logic [7:0]          cfg_sync_byte,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [1:0]          cfg_steps,
    output logic                restart
);
    localparam int CFG_W = 1 + 8 + PERIOD_W + 2;

    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;

    assign cfg_now = {cfg_serial, cfg_sync_byte, cfg_period, cfg_steps};

    // Always tracks the inputs, also in reset, so release never looks like a change
    always_ff @(posedge clk) begin
        cfg_q <= cfg_now;
    end

    assign restart = rst || (cfg_now != cfg_q);

endmodule

// File: rtl/ts_byte_align.sv
module ts_byte_align
    import ts_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       serial,
    input  logic [7:0] sync_byte,
    input  logic       clear,
    input  logic       par_valid,
    input  logic [7:0] par_byte,
    input  logic       ser_valid,
    input  logic       ser_bit,
    output abyte_t     al
);
    logic [7:0] win;
    logic [7:0] win_next;
    logic [2:0] phase;
    logic       locked;

    assign win_next = {win[6:0], ser_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            win    <= '0;
            phase  <= '0;
            locked <= 1'b0;
            al     <= '0;
        end else begin
            al.vld <= 1'b0;
            if (ser_valid) begin
                win <= win_next;
            end
            if (clear) begin
                locked <= 1'b0;
                phase  <= '0;
            end else if (!serial) begin
                al.vld  <= par_valid;
                al.data <= par_byte;
            end else if (ser_valid) begin
                if (!locked) begin
                    // Hunting: only a marker match at any offset leaves here
                    if (win_next == sync_byte) begin
                        al.vld  <= 1'b1;
                        al.data <= win_next;
                        locked  <= 1'b1;
                        phase   <= '0;
                    end
                end else begin
                    if (phase == 3'd7) begin
                        al.vld  <= 1'b1;
                        al.data <= win_next;
                    end
                    phase <= phase + 3'd1;
                end
            end
        end
    end

endmodule

// File: rtl/ts_flywheel.sv
module ts_flywheel
    import ts_sync_pkg::*;
#(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                restart,
    input  abyte_t              al,
    input  logic [7:0]          sync_byte,
    input  logic [PERIOD_W-1:0] period,
    input  logic [2:0]          ts,
    output logic                go_search,
    output logic                sync_ok,
    output logic                pkt_start,
    output logic                out_valid,
    output logic [7:0]          out_byte
);
    fw_state_e           st, st_n;
    logic [PERIOD_W-1:0] pos, pos_n, pos_adv;
    logic [2:0]          hits, hits_n;
    logic [2:0]          misses, misses_n;
    logic                at_mark;
    logic                hit;

    assign at_mark = (pos == '0);
    assign hit     = (al.data == sync_byte);
    assign pos_adv = (pos == period - PERIOD_W'(1)) ? '0 : pos + PERIOD_W'(1);

    always_comb begin
        st_n     = st;
        pos_n    = pos;
        hits_n   = hits;
        misses_n = misses;
        if (al.vld) begin
            case (st)
                FW_SEARCH: begin
                    if (hit) begin
                        st_n   = FW_ACQ;
                        hits_n = 3'd1;
                        pos_n  = PERIOD_W'(1);
                    end
                end
                FW_ACQ: begin
                    pos_n = pos_adv;
                    if (at_mark) begin
                        if (hit) begin
                            hits_n = hits + 3'd1;
                            if (hits + 3'd1 >= ts) begin
                                st_n     = FW_TRACK;
                                misses_n = '0;
                            end
                        end else begin
                            st_n = FW_SEARCH;
                        end
                    end
                end
                FW_TRACK: begin
                    pos_n = pos_adv;
                    if (at_mark) begin
                        if (hit) begin
                            misses_n = '0;
                        end else begin
                            misses_n = misses + 3'd1;
                            if (misses + 3'd1 >= ts) begin
                                st_n = FW_SEARCH;
                            end
                        end
                    end
                end
                default: st_n = FW_SEARCH;
            endcase
        end
    end

    assign go_search = restart || ((st != FW_SEARCH) && (st_n == FW_SEARCH));

    always_ff @(posedge clk) begin
        if (restart) begin
            st        <= FW_SEARCH;
            pos       <= '0;
            hits      <= '0;
            misses    <= '0;
            sync_ok   <= 1'b0;
            pkt_start <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            st        <= st_n;
            pos       <= pos_n;
            hits      <= hits_n;
            misses    <= misses_n;
            sync_ok   <= (st_n == FW_TRACK);
            out_valid <= al.vld && (st_n == FW_TRACK);
            pkt_start <= al.vld && at_mark && (st != FW_SEARCH) && (st_n == FW_TRACK);
            if (al.vld) begin
                out_byte <= al.data;
            end
        end
    end

endmodule

// File: rtl/ts_sync_acq.sv
module ts_sync_acq
    import ts_sync_pkg::*;
#(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_serial,
    input  logic [7:0]          cfg_sync_byte,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [1:0]          cfg_steps,
    input  logic                par_valid,
    input  logic [7:0]          par_byte,
    input  logic                ser_valid,
    input  logic                ser_bit,
    output logic                sync_ok,
    output logic                pkt_start,
    output logic                out_valid,
    output logic [7:0]          out_byte
);
    logic   restart;
    logic   go_search;
    abyte_t al;

    ts_cfg_watch #(.PERIOD_W(PERIOD_W)) u_cfg (
        .clk           (clk),
        .rst           (rst),
        .cfg_serial    (cfg_serial),
        .cfg_sync_byte (cfg_sync_byte),
        .cfg_period    (cfg_period),
        .cfg_steps     (cfg_steps),
        .restart       (restart)
    );

    ts_byte_align u_align (
        .clk       (clk),
        .rst       (rst),
        .serial    (cfg_serial),
        .sync_byte (cfg_sync_byte),
        .clear     (go_search),
        .par_valid (par_valid),
        .par_byte  (par_byte),
        .ser_valid (ser_valid),
        .ser_bit   (ser_bit),
        .al        (al)
    );

    ts_flywheel #(.PERIOD_W(PERIOD_W)) u_fw (
        .clk       (clk),
        .restart   (restart),
        .al        (al),
        .sync_byte (cfg_sync_byte),
        .period    (cfg_period),
        .ts        (steps_decode(cfg_steps)),
        .go_search (go_search),
        .sync_ok   (sync_ok),
        .pkt_start (pkt_start),
        .out_valid (out_valid),
        .out_byte  (out_byte)
    );

endmodule

// File: rtl/ts_sync_acq_chk.sv
module ts_sync_acq_chk #(
    parameter int PERIOD_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_serial,
    input logic [7:0]          cfg_sync_byte,
    input logic [PERIOD_W-1:0] cfg_period,
    input logic [1:0]          cfg_steps,
    input logic                sync_ok,
    input logic                pkt_start,
    input logic                out_valid,
    input logic [7:0]          out_byte
);
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sync_ok && !pkt_start && !out_valid));

    assert_lock_on_marker_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_ok) |-> (pkt_start && out_byte == $past(cfg_sync_byte)));

    assert_strobe_in_lock_R7: assert property (@(posedge clk) disable iff (rst)
        pkt_start |-> (sync_ok && out_valid));

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        pkt_start && $past(cfg_period) != 1 && $stable(cfg_period) |=> !pkt_start);

    assert_valid_needs_lock_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> sync_ok);

    assert_cfg_change_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cfg_serial) || !$stable(cfg_sync_byte) ||
         !$stable(cfg_period) || !$stable(cfg_steps)) |=> !sync_ok);

endmodule

bind ts_sync_acq ts_sync_acq_chk #(.PERIOD_W(PERIOD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_serial    (cfg_serial),
    .cfg_sync_byte (cfg_sync_byte),
    .cfg_period    (cfg_period),
    .cfg_steps     (cfg_steps),
    .sync_ok       (sync_ok),
    .pkt_start     (pkt_start),
    .out_valid     (out_valid),
    .out_byte      (out_byte)
);

// File: tb/ts_sync_acq_tb.sv
module ts_sync_acq_tb;
    import ts_sync_pkg::*;

    localparam int PW = 8;

    typedef struct packed {
        logic       ser;
        logic [1:0] steps;
        logic [7:0] per;
        logic [7:0] sb;
        logic [3:0] off;
        logic [2:0] ts;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd0, 8'(DEF_PERIOD), DEF_SYNC_BYTE, 4'd5, 3'd3},
        '{1'b0, 2'd1, 8'd12,  8'h1D, 4'd0, 3'd4},
        '{1'b0, 2'd2, 8'd9,   8'hB8, 4'd3, 3'd5},
        '{1'b0, 2'd3, 8'd2,   8'h47, 4'd1, 3'd5},
        '{1'b1, 2'd0, 8'd10,  8'h47, 4'd0, 3'd3},
        '{1'b1, 2'd1, 8'd6,   8'h47, 4'd3, 3'd4},
        '{1'b1, 2'd2, 8'd8,   8'h47, 4'd7, 3'd5}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_serial;
    logic [7:0]    cfg_sync_byte;
    logic [PW-1:0] cfg_period;
    logic [1:0]    cfg_steps;
    logic          par_valid;
    logic [7:0]    par_byte;
    logic          ser_valid;
    logic          ser_bit;
    logic          sync_ok;
    logic          pkt_start;
    logic          out_valid;
    logic [7:0]    out_byte;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ts_sync_acq #(.PERIOD_W(PW)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .cfg_serial    (cfg_serial),
        .cfg_sync_byte (cfg_sync_byte),
        .cfg_period    (cfg_period),
        .cfg_steps     (cfg_steps),
        .par_valid     (par_valid),
        .par_byte      (par_byte),
        .ser_valid     (ser_valid),
        .ser_bit       (ser_bit),
        .sync_ok       (sync_ok),
        .pkt_start     (pkt_start),
        .out_valid     (out_valid),
        .out_byte      (out_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One byte in byte mode; on return the outputs reflect that byte
    task automatic send_byte(input logic [7:0] b);
        par_valid = 1'b1;
        par_byte  = b;
        @(negedge clk);
        par_valid = 1'b0;
        @(negedge clk);
    endtask

    // One byte in bit mode, MSB first, then one idle cycle
    task automatic send_ser(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            ser_valid = 1'b1;
            ser_bit   = b[i];
            @(negedge clk);
        end
        ser_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_any(input logic ser, input logic [7:0] b);
        if (ser) send_ser(b);
        else     send_byte(b);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic setup(input logic ser, input logic [1:0] steps,
                         input logic [7:0] per, input logic [7:0] sb);
        cfg_serial    = ser;
        cfg_steps     = steps;
        cfg_period    = per;
        cfg_sync_byte = sb;
        do_reset();
    endtask

    // Byte-mode packet: marker (or substitute) plus payload
    task automatic par_pkt(input logic [7:0] head, input int per);
        send_byte(head);
    endtask

    task automatic par_payload(input int per);
        for (int j = 1; j < per; j++) send_byte(8'h5A);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_serial = 1'b0; cfg_sync_byte = DEF_SYNC_BYTE;
        cfg_period = PW'(DEF_PERIOD); cfg_steps = 2'd0;
        par_valid = 1'b0; par_byte = '0; ser_valid = 1'b0; ser_bit = 1'b0;
        @(negedge clk);
        do_reset();

        // R1: state after reset
        check("R1", sync_ok, 0);
        check("R1", pkt_start, 0);
        check("R1", out_valid, 0);

        // Table walk: R2 (byte mode, TS decode, periods) and R3 (bit offsets)
        for (int v = 0; v < NVEC; v++) begin
            setup(VECS[v].ser, VECS[v].steps, VECS[v].per, VECS[v].sb);
            for (int g = 0; g < int'(VECS[v].off); g++) begin
                if (VECS[v].ser) begin
                    ser_valid = 1'b1; ser_bit = 1'b0;
                    @(negedge clk);
                    ser_valid = 1'b0;
                end else begin
                    send_byte(8'h00);
                end
            end
            for (int k = 1; k <= int'(VECS[v].ts) + 1; k++) begin
                send_any(VECS[v].ser, VECS[v].sb);
                check(VECS[v].ser ? "R3" : "R2", sync_ok, (k >= int'(VECS[v].ts)));
                check("R7", pkt_start, (k >= int'(VECS[v].ts)));
                if (k >= int'(VECS[v].ts))
                    check(VECS[v].ser ? "R3" : "R8", out_byte, VECS[v].sb);
                for (int j = 1; j < int'(VECS[v].per); j++) send_any(VECS[v].ser, 8'h00);
            end
        end

        // R4: marker corrupted during acquisition, TS=4, period 8
        setup(1'b0, 2'd1, 8'd8, 8'h47);
        for (int k = 0; k < 2; k++) begin par_pkt(8'h47, 8); par_payload(8); end
        par_pkt(8'h46, 8);
        check("R4", sync_ok, 0);
        par_payload(8);
        for (int k = 1; k <= 4; k++) begin
            par_pkt(8'h47, 8);
            check("R4", sync_ok, (k == 4));
            if (k < 4) par_payload(8);
        end
        check("R7", pkt_start, 1);
        send_byte(8'h5A);
        check("R8", out_valid, 1);
        check("R8", out_byte, 8'h5A);
        check("R7", pkt_start, 0);
        for (int j = 2; j < 8; j++) send_byte(8'h5A);

        // R5/R6: misses while locked, TS=3, period 6
        setup(1'b0, 2'd0, 8'd6, 8'h47);
        for (int k = 1; k <= 3; k++) begin par_pkt(8'h47, 6); par_payload(6); end
        check("R2", sync_ok, 1);
        par_pkt(8'h00, 6);
        check("R6", sync_ok, 1);
        check("R7", pkt_start, 1);
        par_payload(6);
        par_pkt(8'h00, 6); check("R6", sync_ok, 1); par_payload(6);
        par_pkt(8'h47, 6); check("R6", sync_ok, 1); par_payload(6);
        par_pkt(8'h00, 6); check("R6", sync_ok, 1); par_payload(6);
        par_pkt(8'h00, 6); check("R6", sync_ok, 1); par_payload(6);
        par_pkt(8'h00, 6);
        check("R5", sync_ok, 0);
        check("R7", pkt_start, 0);
        send_byte(8'h5A);
        check("R8", out_valid, 0);

        // R9: configuration change while locked
        for (int k = 1; k <= 4; k++) begin par_pkt(8'h47, 6); par_payload(6); end
        check("R2", sync_ok, 1);
        cfg_period = 8'd7;
        @(negedge clk);
        check("R9", sync_ok, 0);
        for (int k = 1; k <= 3; k++) begin par_pkt(8'h47, 7); par_payload(7); end
        check("R2", sync_ok, 1);
        cfg_steps = 2'd1;
        @(negedge clk);
        check("R9", sync_ok, 0);

        // R1: reset while locked
        for (int k = 1; k <= 4; k++) begin par_pkt(8'h47, 7); par_payload(7); end
        check("R2", sync_ok, 1);
        rst = 1'b1;
        @(negedge clk);
        check("R1", sync_ok, 0);
        check("R1", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule